// File: doc/BRIEF.md
# Region-Decoding Register Slave with Error Bus

This block is an AXI4-Lite slave that sits in front of a control engine. It maps the register window into three regions: a writable configuration bank, a writable calendar bank and a read-only status region whose words come from the engine itself. Stored configuration and calendar words are driven out as flat vectors, so the control logic can use them directly.

Each write that the slave commits yields one write response. Responses are held in a small in-order queue until the master takes them. The depth of this queue bounds the number of responses that can be outstanding. When the queue is full, the slave stops accepting any new address or data on every channel. An 8-bit sideband error bus tells the master why a transaction failed. One bit shows that the queue is full. One bit each flags a failed write to one of the three regions. One more bit flags an address that hits nothing.

Top module: `ctrl_region_slave`

## Requirements
- R1: Every committed write pushes exactly one response into a first-in first-out queue. BVALID is high while at least one response is waiting, and BRESP shows the oldest waiting response.
- R2: BVALID and BRESP hold steady while BREADY is low. Each rising edge with BVALID and BREADY both high removes exactly one response.
- R3: The queue holds up to RSP_DEPTH responses. While it is full, err_o[0] is high and AWREADY, WREADY and ARREADY are low, so a pending read is also stalled. One completed B handshake clears the full state, and the stalled read then proceeds. A commit and a B handshake in the same cycle leave the number of waiting responses unchanged.
- R4: The write address and the write data may be accepted in either order or in the same cycle. The write commits only once both are held. A lone write address produces no response.
- R5: The region is selected by address bits [ADDR_W-1:ADDR_W-2]: 0 is configuration, 1 is calendar, 2 is status and 3 is unmapped. The word index is taken from bits [ADDR_W-3:2]. A location is mapped only when its index is below the word count of its region.
- R6: A write with all WSTRB bits set to a mapped configuration or calendar word stores the data. That word then appears on cfg_regs_o or cal_regs_o (word i at bits [i*DATA_W +: DATA_W]) and reads back with the response OKAY (2'b00).
- R7: A write to a mapped configuration word with any WSTRB bit clear fails. It returns SLVERR (2'b10), leaves the word unchanged and pulses err_o[1].
- R8: A write to a mapped calendar word with any WSTRB bit clear fails. It returns SLVERR, leaves the word unchanged and pulses err_o[2].
- R9: Any write to a mapped status word returns SLVERR and pulses err_o[3].
- R10: A read or write to an unmapped location returns DECERR (2'b11) and pulses err_o[4]. It changes no register, and such a read returns zero data. Being unmapped takes precedence over a region failure.
- R11: A read of mapped status word i returns status_in[i*DATA_W +: DATA_W] with OKAY.
- R12: err_o[4:1] are one-cycle pulses. A write pulse is raised in the cycle its response enters the queue, and a read pulse in the cycle RVALID rises. err_o[7:5] are always low, and after reset err_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| axil_awvalid | input | 1 | Write address valid |
| axil_awready | output | 1 | Write address ready |
| axil_awaddr | input | ADDR_W | Write byte address |
| axil_wvalid | input | 1 | Write data valid |
| axil_wready | output | 1 | Write data ready |
| axil_wdata | input | DATA_W | Write data |
| axil_wstrb | input | DATA_W/8 | Write byte strobes |
| axil_bvalid | output | 1 | Write response valid |
| axil_bready | input | 1 | Write response ready |
| axil_bresp | output | 2 | Write response code |
| axil_arvalid | input | 1 | Read address valid |
| axil_arready | output | 1 | Read address ready |
| axil_araddr | input | ADDR_W | Read byte address |
| axil_rvalid | output | 1 | Read data valid |
| axil_rready | input | 1 | Read data ready |
| axil_rdata | output | DATA_W | Read data |
| axil_rresp | output | 2 | Read response code |
| status_in | input | STAT_WORDS*DATA_W | Status words supplied by the control engine |
| cfg_regs_o | output | CFG_WORDS*DATA_W | Stored configuration words, flat |
| cal_regs_o | output | CAL_WORDS*DATA_W | Stored calendar words, flat |
| err_o | output | 8 | Sideband error bus |

## Verification
The bench builds the slave with RSP_DEPTH=2, CFG_WORDS=4, CAL_WORDS=8 and STAT_WORDS=2. Two withheld responses are then enough to fill the queue. That makes the stall of all three channels, and its release by a single B handshake, reachable in a few cycles. The small word counts leave index holes in every region, so the decode can be probed at the first index past the end of each region and not only in the unmapped quarter. Holding BREADY low also lets the bench check that responses leave in write order. A commit can be made to land on the same edge as a pop.

// File: rtl/ctrl_slave_pkg.sv
package ctrl_slave_pkg;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_CAL  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } region_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/ctrl_addr_decode.sv
module ctrl_addr_decode
    import ctrl_slave_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CFG_WORDS  = 8,
    parameter int CAL_WORDS  = 16,
    parameter int STAT_WORDS = 4,
    localparam int IDX_W     = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              hit,
    output logic [IDX_W-1:0]  index
);
    localparam logic [IDX_W:0] CFG_LIM  = (IDX_W+1)'(CFG_WORDS);
    localparam logic [IDX_W:0] CAL_LIM  = (IDX_W+1)'(CAL_WORDS);
    localparam logic [IDX_W:0] STAT_LIM = (IDX_W+1)'(STAT_WORDS);

    logic unused_byte_lane;
    assign unused_byte_lane = ^addr[1:0];

    always_comb begin
        region = region_e'(addr[ADDR_W-1 -: 2]);
        index  = addr[ADDR_W-3:2];
        case (region)
            REG_CFG:  hit = {1'b0, index} < CFG_LIM;
            REG_CAL:  hit = {1'b0, index} < CAL_LIM;
            REG_STAT: hit = {1'b0, index} < STAT_LIM;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [IDX_W-1:0]        ridx,
    output logic [DATA_W-1:0]       rdata,
    output logic [WORDS*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (we && widx == IDX_W'(i)) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (ridx == IDX_W'(i)) begin
                rdata = mem_q[i];
            end
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign flat[g*DATA_W +: DATA_W] = mem_q[g];
    end

endmodule

// File: rtl/ctrl_rsp_queue.sv
module ctrl_rsp_queue #(
    parameter int DEPTH  = 4,
    parameter int RESP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RESP_W-1:0] push_resp,
    input  logic              pop,
    output logic              valid,
    output logic [RESP_W-1:0] resp,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t           q_d, q_q;
    logic [RESP_W-1:0] slot_d [DEPTH];
    logic [RESP_W-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (push) begin
            slot_d[q_q.wr] = push_resp;
            q_d.wr = advance(q_q.wr);
        end
        if (pop) begin
            q_d.rd = advance(q_q.rd);
        end
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            q_q <= q_d;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign valid = q_q.cnt != '0;
    assign resp  = slot_q[q_q.rd];
    assign full  = q_q.cnt == CNT_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(valid) && $stable(full)); // R3
    AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> valid && $stable(resp)); // R2

endmodule

// File: rtl/ctrl_region_slave.sv
module ctrl_region_slave
    import ctrl_slave_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int CFG_WORDS  = 8,
    parameter int CAL_WORDS  = 16,
    parameter int STAT_WORDS = 4,
    parameter int RSP_DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         axil_awvalid,
    output logic                         axil_awready,
    input  logic [ADDR_W-1:0]            axil_awaddr,
    input  logic                         axil_wvalid,
    output logic                         axil_wready,
    input  logic [DATA_W-1:0]            axil_wdata,
    input  logic [DATA_W/8-1:0]          axil_wstrb,
    output logic                         axil_bvalid,
    input  logic                         axil_bready,
    output logic [1:0]                   axil_bresp,
    input  logic                         axil_arvalid,
    output logic                         axil_arready,
    input  logic [ADDR_W-1:0]            axil_araddr,
    output logic                         axil_rvalid,
    input  logic                         axil_rready,
    output logic [DATA_W-1:0]            axil_rdata,
    output logic [1:0]                   axil_rresp,
    input  logic [STAT_WORDS*DATA_W-1:0] status_in,
    output logic [CFG_WORDS*DATA_W-1:0]  cfg_regs_o,
    output logic [CAL_WORDS*DATA_W-1:0]  cal_regs_o,
    output logic [7:0]                   err_o
);
    localparam int IDX_W  = ADDR_W - 4;
    localparam int STRB_W = DATA_W / 8;

    // flag[0..3] drive err_o[1..4]
    typedef struct packed {
        logic              aw_v;
        logic [ADDR_W-1:0] aw_addr;
        logic              w_v;
        logic [DATA_W-1:0] w_data;
        logic [STRB_W-1:0] w_strb;
        logic              r_v;
        logic [DATA_W-1:0] r_data;
        logic [1:0]        r_resp;
        logic [3:0]        flag;
    } slave_t;

    slave_t s_d, s_q;

    region_e           w_region, r_region;
    logic              w_hit, r_hit;
    logic [IDX_W-1:0]  w_idx, r_idx;
    logic [DATA_W-1:0] cfg_rd, cal_rd, stat_rd, rd_mux;
    logic              commit, cfg_we, cal_we, rsp_full;
    logic [1:0]        w_resp;
    logic [3:0]        w_flag;
    logic              aw_hs, w_hs, ar_hs;

    ctrl_addr_decode #(
        .ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS),
        .CAL_WORDS(CAL_WORDS), .STAT_WORDS(STAT_WORDS)
    ) u_wdec (
        .addr(s_q.aw_addr), .region(w_region), .hit(w_hit), .index(w_idx)
    );

    ctrl_addr_decode #(
        .ADDR_W(ADDR_W), .CFG_WORDS(CFG_WORDS),
        .CAL_WORDS(CAL_WORDS), .STAT_WORDS(STAT_WORDS)
    ) u_rdec (
        .addr(axil_araddr), .region(r_region), .hit(r_hit), .index(r_idx)
    );

    ctrl_reg_bank #(.WORDS(CFG_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(w_idx),
        .wdata(s_q.w_data), .ridx(r_idx), .rdata(cfg_rd), .flat(cfg_regs_o)
    );

    ctrl_reg_bank #(.WORDS(CAL_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cal (
        .clk(clk), .rst_n(rst_n), .we(cal_we), .widx(w_idx),
        .wdata(s_q.w_data), .ridx(r_idx), .rdata(cal_rd), .flat(cal_regs_o)
    );

    ctrl_rsp_queue #(.DEPTH(RSP_DEPTH), .RESP_W(2)) u_rspq (
        .clk(clk), .rst_n(rst_n), .push(commit), .push_resp(w_resp),
        .pop(axil_bvalid && axil_bready), .valid(axil_bvalid),
        .resp(axil_bresp), .full(rsp_full)
    );

    assign axil_awready = !s_q.aw_v && !rsp_full;
    assign axil_wready  = !s_q.w_v  && !rsp_full;
    assign axil_arready = !s_q.r_v  && !rsp_full;
    assign aw_hs = axil_awvalid && axil_awready;
    assign w_hs  = axil_wvalid  && axil_wready;
    assign ar_hs = axil_arvalid && axil_arready;
    assign commit = s_q.aw_v && s_q.w_v;

    // Write outcome for the held address/data pair
    always_comb begin
        cfg_we = 1'b0;
        cal_we = 1'b0;
        w_resp = RESP_OKAY;
        w_flag = '0;
        if (commit) begin
            if (!w_hit) begin
                w_resp    = RESP_DECERR;
                w_flag[3] = 1'b1;
            end else begin
                case (w_region)
                    REG_CFG: begin
                        if (&s_q.w_strb) begin
                            cfg_we = 1'b1;
                        end else begin
                            w_resp    = RESP_SLVERR;
                            w_flag[0] = 1'b1;
                        end
                    end
                    REG_CAL: begin
                        if (&s_q.w_strb) begin
                            cal_we = 1'b1;
                        end else begin
                            w_resp    = RESP_SLVERR;
                            w_flag[1] = 1'b1;
                        end
                    end
                    default: begin
                        w_resp    = RESP_SLVERR;
                        w_flag[2] = 1'b1;
                    end
                endcase
            end
        end
    end

    // Status word select and read source mux
    always_comb begin
        stat_rd = '0;
        for (int i = 0; i < STAT_WORDS; i++) begin
            if (r_idx == IDX_W'(i)) begin
                stat_rd = status_in[i*DATA_W +: DATA_W];
            end
        end
        case (r_region)
            REG_CFG:  rd_mux = cfg_rd;
            REG_CAL:  rd_mux = cal_rd;
            REG_STAT: rd_mux = stat_rd;
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.flag = w_flag;
        if (commit) begin
            s_d.aw_v = 1'b0;
            s_d.w_v  = 1'b0;
        end
        if (aw_hs) begin
            s_d.aw_v    = 1'b1;
            s_d.aw_addr = axil_awaddr;
        end
        if (w_hs) begin
            s_d.w_v    = 1'b1;
            s_d.w_data = axil_wdata;
            s_d.w_strb = axil_wstrb;
        end
        if (ar_hs) begin
            s_d.r_v    = 1'b1;
            s_d.r_data = r_hit ? rd_mux : '0;
            s_d.r_resp = r_hit ? RESP_OKAY : RESP_DECERR;
            if (!r_hit) begin
                s_d.flag[3] = 1'b1;
            end
        end else if (s_q.r_v && axil_rready) begin
            s_d.r_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign axil_rvalid = s_q.r_v;
    assign axil_rdata  = s_q.r_data;
    assign axil_rresp  = s_q.r_resp;
    assign err_o       = {3'b000, s_q.flag, rsp_full};

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> !(axil_awready || axil_wready || axil_arready)); // R3
    AST_WRITE_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> axil_bvalid); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (axil_rvalid && !axil_rready) |=> axil_rvalid && $stable(axil_rdata)); // R11
    AST_DECERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(axil_rvalid) && axil_rresp == RESP_DECERR) |-> err_o[4]); // R10
    AST_COMMIT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_hs && !s_q.w_v && !w_hs) |=> !axil_wready || !commit); // R4

endmodule

// File: tb/tb_ctrl_region_slave.sv
`timescale 1ns/1ps
module tb_ctrl_region_slave;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NCFG = 4;
    localparam int NCAL = 8;
    localparam int NSTAT = 2;
    localparam int DEPTH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DW-1:0] rdata;
    logic [NSTAT*DW-1:0] status_in = {32'h5A5A0001, 32'hA5A50000};
    logic [NCFG*DW-1:0] cfg_regs;
    logic [NCAL*DW-1:0] cal_regs;
    logic [7:0] err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ctrl_region_slave #(
        .ADDR_W(AW), .DATA_W(DW), .CFG_WORDS(NCFG), .CAL_WORDS(NCAL),
        .STAT_WORDS(NSTAT), .RSP_DEPTH(DEPTH)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .axil_awvalid(awvalid), .axil_awready(awready), .axil_awaddr(awaddr),
        .axil_wvalid(wvalid), .axil_wready(wready), .axil_wdata(wdata), .axil_wstrb(wstrb),
        .axil_bvalid(bvalid), .axil_bready(bready), .axil_bresp(bresp),
        .axil_arvalid(arvalid), .axil_arready(arready), .axil_araddr(araddr),
        .axil_rvalid(rvalid), .axil_rready(rready), .axil_rdata(rdata), .axil_rresp(rresp),
        .status_in(status_in), .cfg_regs_o(cfg_regs), .cal_regs_o(cal_regs), .err_o(err)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [1:0]  resp;
        logic [7:0]  err;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h11111111, 4'hF, 2'b00, 8'h00, 32'h0},
        '{1'b1, 12'h004, 32'h22222222, 4'hF, 2'b00, 8'h00, 32'h0},
        '{1'b0, 12'h004, 32'h0,        4'h0, 2'b00, 8'h00, 32'h22222222},
        '{1'b1, 12'h008, 32'h33333333, 4'h3, 2'b10, 8'h02, 32'h0},
        '{1'b0, 12'h008, 32'h0,        4'h0, 2'b00, 8'h00, 32'h0},
        '{1'b1, 12'h400, 32'hCAFE0001, 4'hF, 2'b00, 8'h00, 32'h0},
        '{1'b1, 12'h404, 32'hDEAD0002, 4'h1, 2'b10, 8'h04, 32'h0},
        '{1'b0, 12'h400, 32'h0,        4'h0, 2'b00, 8'h00, 32'hCAFE0001},
        '{1'b0, 12'h404, 32'h0,        4'h0, 2'b00, 8'h00, 32'h0},
        '{1'b1, 12'h800, 32'h12345678, 4'hF, 2'b10, 8'h08, 32'h0},
        '{1'b0, 12'h800, 32'h0,        4'h0, 2'b00, 8'h00, 32'hA5A50000},
        '{1'b0, 12'h804, 32'h0,        4'h0, 2'b00, 8'h00, 32'h5A5A0001},
        '{1'b1, 12'h010, 32'h44444444, 4'hF, 2'b11, 8'h10, 32'h0},
        '{1'b0, 12'h420, 32'h0,        4'h0, 2'b11, 8'h10, 32'h0},
        '{1'b1, 12'hC00, 32'h55555555, 4'h3, 2'b11, 8'h10, 32'h0},
        '{1'b0, 12'h808, 32'h0,        4'h0, 2'b11, 8'h10, 32'h0},
        '{1'b1, 12'h80C, 32'h66666666, 4'hF, 2'b11, 8'h10, 32'h0},
        '{1'b0, 12'hC04, 32'h0,        4'h0, 2'b11, 8'h10, 32'h0},
        '{1'b1, 12'h01C, 32'h77777777, 4'hF, 2'b11, 8'h10, 32'h0},
        '{1'b0, 12'h00C, 32'h0,        4'h0, 2'b00, 8'h00, 32'h0}
    };

    function automatic string vtag(vec_t v);
        if (v.err[4]) return "R5 R10";
        if (v.err[3]) return "R9";
        if (v.err[2]) return "R8";
        if (v.err[1]) return "R7";
        if (!v.wr && v.addr[11:10] == 2'd2) return "R11";
        return "R5 R6";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // mode 0: address first, 1: data first, 2: both together
    task automatic send_write(input logic [11:0] a, input logic [31:0] d,
                              input logic [3:0] s, input int mode);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        if (mode == 2) begin
            awvalid = 1'b1; wvalid = 1'b1;
            while (!(awready && wready)) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
        end else if (mode == 0) begin
            awvalid = 1'b1;
            while (!awready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            wvalid = 1'b0;
        end else begin
            wvalid = 1'b1;
            while (!wready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            wvalid = 1'b0; awvalid = 1'b1;
            while (!awready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            awvalid = 1'b0;
        end
    endtask

    task automatic wait_b();
        while (!bvalid) @(negedge clk);
    endtask

    task automatic send_read(input logic [11:0] a);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "err after reset", {24'h0, err}, 32'h0);
        check("R1", "bvalid after reset", {31'h0, bvalid}, 32'h0);
        check("R3", "readies after reset", {29'h0, awready, wready, arready}, 32'h7);
        check("R6", "cfg regs after reset", cfg_regs[31:0], 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                send_write(VECS[i].addr, VECS[i].data, VECS[i].strb, i % 3);
                wait_b();
                check(vtag(VECS[i]), $sformatf("bresp vec %0d R4 order", i),
                      {30'h0, bresp}, {30'h0, VECS[i].resp});
                check("R12", $sformatf("err vec %0d", i), {24'h0, err}, {24'h0, VECS[i].err});
            end else begin
                send_read(VECS[i].addr);
                check(vtag(VECS[i]), $sformatf("rvalid vec %0d", i), {31'h0, rvalid}, 32'h1);
                check(vtag(VECS[i]), $sformatf("rresp vec %0d", i),
                      {30'h0, rresp}, {30'h0, VECS[i].resp});
                check(vtag(VECS[i]), $sformatf("rdata vec %0d", i), rdata, VECS[i].rdata);
                check("R12", $sformatf("err vec %0d", i), {24'h0, err}, {24'h0, VECS[i].err});
            end
        end
        @(negedge clk);
        check("R6", "cfg word0 out", cfg_regs[31:0], 32'h11111111);
        check("R6", "cfg word1 out", cfg_regs[63:32], 32'h22222222);
        check("R7", "cfg word2 unchanged", cfg_regs[95:64], 32'h0);
        check("R6", "cal word0 out", cal_regs[31:0], 32'hCAFE0001);
        check("R8", "cal word1 unchanged", cal_regs[63:32], 32'h0);
        check("R10", "cfg word3 untouched by holes", cfg_regs[127:96], 32'h0);
        check("R12", "pulse gone", {24'h0, err}, 32'h0);

        // R4: a lone address never commits
        @(negedge clk);
        awaddr = 12'h00C; awvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        repeat (3) @(negedge clk);
        check("R4", "no response without data", {31'h0, bvalid}, 32'h0);
        check("R4", "address slot held", {31'h0, awready}, 32'h0);
        wdata = 32'h0000ABCD; wstrb = 4'hF; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wvalid = 1'b0;
        wait_b();
        check("R4", "late data commits", {30'h0, bresp}, 32'h0);
        @(negedge clk);
        check("R4", "late data stored", cfg_regs[127:96], 32'h0000ABCD);

        // R1 R2 R3: fill queue, stall, ordering
        bready = 1'b0;
        send_write(12'h00C, 32'h00000077, 4'hF, 0);
        @(negedge clk);
        check("R1", "first response waiting", {31'h0, bvalid}, 32'h1);
        send_write(12'h008, 32'h00000099, 4'h1, 1);
        @(negedge clk);
        check("R3", "full flag", {31'h0, err[0]}, 32'h1);
        check("R3", "all channels stalled", {29'h0, awready, wready, arready}, 32'h0);
        check("R2", "oldest response held", {30'h0, bresp}, 32'h0);
        araddr = 12'h00C; arvalid = 1'b1;
        repeat (3) @(negedge clk);
        check("R3", "read stalled while full", {31'h0, rvalid}, 32'h0);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        check("R3", "full cleared by one pop", {31'h0, err[0]}, 32'h0);
        check("R1", "second response in order", {30'h0, bresp}, 32'h2);
        check("R2", "one pop removes one", {31'h0, bvalid}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        check("R3", "stalled read resumes", rdata, 32'h00000077);
        bready = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", "queue drained", {31'h0, bvalid}, 32'h0);

        // R3: commit and pop on the same edge
        bready = 1'b0;
        send_write(12'h000, 32'h00000001, 4'hF, 2);
        @(negedge clk);
        send_write(12'h800, 32'h00000002, 4'hF, 2);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        check("R3", "count held on push+pop", {31'h0, bvalid}, 32'h1);
        check("R3", "survivor is newer", {30'h0, bresp}, 32'h2);
        check("R12", "status write pulse", {24'h0, err}, 32'h08);
        @(negedge clk);
        check("R12", "pulse one cycle", {24'h0, err}, 32'h0);
        bready = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", "drained again", {31'h0, bvalid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule